// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block sits beside an SPI shift engine and owns the active-low chip-select lines. For every word the engine moves, it asserts the chip selects chosen by software. It waits a programmable setup time before it lets the engine start. After the engine reports the end of the word, it keeps the chip select low for a programmable release time and then returns the lines to their idle levels. A hold flag can keep the selection asserted from one word to the next, so that a multi-word frame runs without gaps on the select line.

In ready-handshake mode, the sequencer waits for the slave to pull an active-low ready line low before each word. After the word, it waits for the slave to let that line go high again. Each of these waits has its own timeout. A missed ready raises a timeout flag and a ready that stays low raises a desynchronisation flag. Both flags abort the word, release the chip select and block new words until software clears them by writing one. All delays and timeouts are counted in module clock cycles. Serialisation and baud-rate division belong to the shift engine.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset, `csN` is all ones, `shiftStart`, `tmoFlag` and `desyncFlag` are 0, and the idle-level register holds all ones.
- R2: While no word is in progress, `csN` equals the idle-level register. A cycle with `idleWr` high loads `idleWrData`, and the new value is visible on `csN` in the following cycle.
- R3: A `wordReq` sampled in the idle state latches `csSel` (a 0 bit asserts that line), and `csN` shows the latched value from the next cycle until the chip select is released.
- R4: The setup delay is `delayCfg[31:24]`. `shiftStart` pulses for one cycle exactly that many cycles after `csN` first asserts, and a value of 0 pulses it in the same cycle that `csN` asserts.
- R5: The release delay is `delayCfg[23:16]`. With hold clear and handshake off, `csN` stays asserted for that many cycles after the cycle following the `shiftDone` pulse. A value of 0 returns to idle levels in the cycle right after `shiftDone`.
- R6: When `timerOff` is 1, both the setup and the release delay are treated as zero, whatever `delayCfg` holds.
- R7: With `csHold` set when a word is accepted, `csN` stays asserted after `shiftDone`. A next `wordReq` relatches `csSel` and pulses `shiftStart` in the following cycle without any setup delay. If `csHold` is seen low with no request pending, the release delay runs and the lines then go idle.
- R8: When `waitEn` is 1, `shiftStart` is issued only in the cycle after `readyN` has been sampled low. This check comes after the setup delay, or right after acceptance for held words.
- R9: In handshake mode, if `readyN` stays high for `delayCfg[7:0]` sampled cycles, `tmoFlag` sets, `csN` returns to idle levels in the same cycle and no `shiftStart` is issued. A value of 0 waits without limit.
- R10: In handshake mode, `readyN` must be sampled high within `delayCfg[15:8]` cycles after `shiftDone`. Otherwise `desyncFlag` sets and `csN` returns to idle at once, with no release delay. A value of 0 waits without limit.
- R11: `tmoFlag` and `desyncFlag` stay set until `clrTmo` or `clrDesync` is high for one cycle. While either flag is set, `wordReq` is ignored.
- R12: When `waitEn` is 0, `readyN` has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csSel | input | NUM_CS | Per-line selection for the next word, 0 asserts |
| csHold | input | 1 | Keep the selection asserted between words |
| delayCfg | input | 4*DLY_W | Setup [31:24], release [23:16], end-ready timeout [15:8], start-ready timeout [7:0] |
| timerOff | input | 1 | Skip setup and release delays |
| waitEn | input | 1 | Enable the slave ready handshake |
| idleWr | input | 1 | Write strobe for the idle-level register |
| idleWrData | input | NUM_CS | New idle levels |
| wordReq | input | 1 | A word is pending for transfer |
| shiftStart | output | 1 | One-cycle start pulse to the shift engine |
| shiftDone | input | 1 | One-cycle end-of-word pulse from the shift engine |
| readyN | input | 1 | Active-low ready from the slave |
| clrTmo | input | 1 | Write-one clear of the timeout flag |
| clrDesync | input | 1 | Write-one clear of the desync flag |
| csN | output | NUM_CS | Active-low chip-select lines |
| tmoFlag | output | 1 | Sticky ready-timeout error |
| desyncFlag | output | 1 | Sticky desynchronisation error |

## Verification
Single words are run with non-zero, zero and timer-disabled delays, and these tell the setup and release counts apart from the bypass paths. A two-word held frame followed by dropping the hold flag separates the held-word path, which has no setup, from the release path. Handshake runs cover four cases: ready arriving late, ready already low, ready never arriving, and a zero timeout with a long wait. Together they distinguish a normal start, a timeout abort, an unbounded wait and a desync abort. Requests made while a flag is set, followed by clear strobes, show the flags are sticky and that they block new words.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WREADY,
    ST_START,
    ST_SHIFT,
    ST_WEND,
    ST_RELEASE,
    ST_HELD
  } seqState_t;

  // Index into the four delay fields; index 0 is the most significant field
  typedef enum logic [1:0] {
    SRC_SETUP   = 2'd0,
    SRC_RELEASE = 2'd1,
    SRC_END_RDY = 2'd2,
    SRC_CS_RDY  = 2'd3
  } cntSrc_t;

  typedef struct packed {
    logic    latchSel;
    logic    cntLoad;
    logic    cntDec;
    cntSrc_t cntSrc;
    logic    csActive;
  } seqStrobe_t;

endpackage

// File: rtl/cs_seq_datapath.sv
module cs_seq_datapath
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DLY_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [NUM_CS-1:0]    csSel,
  input  logic                 csHold,
  input  logic [4*DLY_W-1:0]   delayCfg,
  input  logic                 idleWr,
  input  logic [NUM_CS-1:0]    idleWrData,
  output logic [NUM_CS-1:0]    csN,
  output logic                 holdLatched,
  output logic                 cntIsOne,
  output logic                 cntIsZero,
  output logic                 setupZero,
  output logic                 releaseZero
);

  localparam int NUM_FIELDS = 4;

  logic [DLY_W-1:0]  fieldVal [NUM_FIELDS];
  logic [DLY_W-1:0]  cnt;
  logic [NUM_CS-1:0] selReg;
  logic [NUM_CS-1:0] idleReg;
  logic              holdReg;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign fieldVal[i] = delayCfg[(NUM_FIELDS-1-i)*DLY_W +: DLY_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      selReg  <= '1;
      holdReg <= 1'b0;
      idleReg <= '1;
    end else begin
      if (idleWr) idleReg <= idleWrData;
      if (strobe.latchSel) begin
        selReg  <= csSel;
        holdReg <= csHold;
      end
      if (strobe.cntLoad)     cnt <= fieldVal[strobe.cntSrc];
      else if (strobe.cntDec) cnt <= cnt - DLY_W'(1);
    end
  end

  assign csN         = strobe.csActive ? selReg : idleReg;
  assign holdLatched = holdReg;
  assign cntIsOne    = (cnt == DLY_W'(1));
  assign cntIsZero   = (cnt == '0);
  assign setupZero   = (fieldVal[SRC_SETUP] == '0);
  assign releaseZero = (fieldVal[SRC_RELEASE] == '0);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntDec |-> cnt != '0);

  // R2
  idle_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleWr |=> idleReg == $past(idleWrData));

endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import cs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordReq,
  input  logic       shiftDone,
  input  logic       readyN,
  input  logic       timerOff,
  input  logic       waitEn,
  input  logic       csHold,
  input  logic       holdLatched,
  input  logic       cntIsOne,
  input  logic       cntIsZero,
  input  logic       setupZero,
  input  logic       releaseZero,
  input  logic       clrTmo,
  input  logic       clrDesync,
  output seqStrobe_t strobe,
  output logic       shiftStart,
  output logic       tmoFlag,
  output logic       desyncFlag
);

  seqState_t state, nextState;
  logic toReady, postWord, toRelease, setTmo, setDsy, errAny;

  assign errAny = tmoFlag | desyncFlag;

  always_comb begin
    nextState       = state;
    strobe          = '0;
    strobe.csActive = (state != ST_IDLE);
    toReady         = 1'b0;
    postWord        = 1'b0;
    toRelease       = 1'b0;
    setTmo          = 1'b0;
    setDsy          = 1'b0;
    case (state)
      ST_IDLE: begin
        if (wordReq && !errAny) begin
          strobe.latchSel = 1'b1;
          if (!timerOff && !setupZero) begin
            nextState      = ST_SETUP;
            strobe.cntLoad = 1'b1;
            strobe.cntSrc  = SRC_SETUP;
          end else begin
            toReady = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (cntIsOne) toReady = 1'b1;
        else          strobe.cntDec = 1'b1;
      end
      ST_WREADY: begin
        if (!readyN) nextState = ST_START;
        else if (cntIsOne) begin
          setTmo    = 1'b1;
          nextState = ST_IDLE;
        end else if (!cntIsZero) strobe.cntDec = 1'b1;
      end
      ST_START: nextState = ST_SHIFT;
      ST_SHIFT: begin
        if (shiftDone) begin
          if (waitEn) begin
            nextState      = ST_WEND;
            strobe.cntLoad = 1'b1;
            strobe.cntSrc  = SRC_END_RDY;
          end else begin
            postWord = 1'b1;
          end
        end
      end
      ST_WEND: begin
        if (readyN) postWord = 1'b1;
        else if (cntIsOne) begin
          setDsy    = 1'b1;
          nextState = ST_IDLE;
        end else if (!cntIsZero) strobe.cntDec = 1'b1;
      end
      ST_RELEASE: begin
        if (cntIsOne) nextState = ST_IDLE;
        else          strobe.cntDec = 1'b1;
      end
      ST_HELD: begin
        if (wordReq && !errAny) begin
          strobe.latchSel = 1'b1;
          toReady         = 1'b1;
        end else if (!csHold) begin
          toRelease = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase

    if (toReady) begin
      if (waitEn) begin
        nextState      = ST_WREADY;
        strobe.cntLoad = 1'b1;
        strobe.cntSrc  = SRC_CS_RDY;
      end else begin
        nextState = ST_START;
      end
    end
    if (postWord) begin
      if (holdLatched) nextState = ST_HELD;
      else             toRelease = 1'b1;
    end
    if (toRelease) begin
      if (timerOff || releaseZero) nextState = ST_IDLE;
      else begin
        nextState      = ST_RELEASE;
        strobe.cntLoad = 1'b1;
        strobe.cntSrc  = SRC_RELEASE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tmoFlag    <= 1'b0;
      desyncFlag <= 1'b0;
    end else begin
      state      <= nextState;
      tmoFlag    <= setTmo | (tmoFlag & ~clrTmo);
      desyncFlag <= setDsy | (desyncFlag & ~clrDesync);
    end
  end

  assign shiftStart = (state == ST_START);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftStart |=> !shiftStart);

  // R8
  start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftStart && waitEn && $past(waitEn)) |-> $past(!readyN));

  // R11
  no_start_with_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftStart |-> !(tmoFlag || desyncFlag));

  // R9
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmoFlag) |-> (state == ST_IDLE) && ($past(state) == ST_WREADY));

  // R10
  dsy_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(desyncFlag) |-> ($past(state) == ST_WEND) && (state == ST_IDLE));

  // R11
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmoFlag && !clrTmo) |=> tmoFlag);

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DLY_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CS-1:0]    csSel,
  input  logic                 csHold,
  input  logic [4*DLY_W-1:0]   delayCfg,
  input  logic                 timerOff,
  input  logic                 waitEn,
  input  logic                 idleWr,
  input  logic [NUM_CS-1:0]    idleWrData,
  input  logic                 wordReq,
  output logic                 shiftStart,
  input  logic                 shiftDone,
  input  logic                 readyN,
  input  logic                 clrTmo,
  input  logic                 clrDesync,
  output logic [NUM_CS-1:0]    csN,
  output logic                 tmoFlag,
  output logic                 desyncFlag
);

  seqStrobe_t strobe;
  logic holdLatched, cntIsOne, cntIsZero, setupZero, releaseZero;

  cs_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wordReq     (wordReq),
    .shiftDone   (shiftDone),
    .readyN      (readyN),
    .timerOff    (timerOff),
    .waitEn      (waitEn),
    .csHold      (csHold),
    .holdLatched (holdLatched),
    .cntIsOne    (cntIsOne),
    .cntIsZero   (cntIsZero),
    .setupZero   (setupZero),
    .releaseZero (releaseZero),
    .clrTmo      (clrTmo),
    .clrDesync   (clrDesync),
    .strobe      (strobe),
    .shiftStart  (shiftStart),
    .tmoFlag     (tmoFlag),
    .desyncFlag  (desyncFlag)
  );

  cs_seq_datapath #(
    .NUM_CS (NUM_CS),
    .DLY_W  (DLY_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .csSel       (csSel),
    .csHold      (csHold),
    .delayCfg    (delayCfg),
    .idleWr      (idleWr),
    .idleWrData  (idleWrData),
    .csN         (csN),
    .holdLatched (holdLatched),
    .cntIsOne    (cntIsOne),
    .cntIsZero   (cntIsZero),
    .setupZero   (setupZero),
    .releaseZero (releaseZero)
  );

endmodule

// File: tb/spi_cs_sequencer_bench.sv
module spi_cs_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  csSel = 8'hFF;
  logic        csHold = 1'b0;
  logic [31:0] delayCfg = '0;
  logic        timerOff = 1'b0;
  logic        waitEn = 1'b0;
  logic        idleWr = 1'b0;
  logic [7:0]  idleWrData = 8'hFF;
  logic        wordReq = 1'b0;
  logic        shiftStart;
  logic        shiftDone = 1'b0;
  logic        readyN = 1'b1;
  logic        clrTmo = 1'b0;
  logic        clrDesync = 1'b0;
  logic [7:0]  csN;
  logic        tmoFlag;
  logic        desyncFlag;

  int cyc = 0;
  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  int         qAt[$];
  logic [7:0] qCs[$];
  bit         qSt[$];
  bit         qTmo[$];
  bit         qDsy[$];
  string      qTag[$];

  spi_cs_sequencer u_spi_cs_sequencer (
    .clk (clk), .rstN (rstN), .csSel (csSel), .csHold (csHold),
    .delayCfg (delayCfg), .timerOff (timerOff), .waitEn (waitEn),
    .idleWr (idleWr), .idleWrData (idleWrData), .wordReq (wordReq),
    .shiftStart (shiftStart), .shiftDone (shiftDone), .readyN (readyN),
    .clrTmo (clrTmo), .clrDesync (clrDesync), .csN (csN),
    .tmoFlag (tmoFlag), .desyncFlag (desyncFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected items when their cycle comes and compares
  always @(negedge clk) begin
    while (qAt.size() > 0 && qAt[0] <= cyc) begin
      checkCnt++;
      if (csN !== qCs[0] || shiftStart !== qSt[0] ||
          tmoFlag !== qTmo[0] || desyncFlag !== qDsy[0]) begin
        failCnt++;
        $display("FAIL %s @%0d: act cs=%h st=%b tmo=%b dsy=%b exp cs=%h st=%b tmo=%b dsy=%b",
                 qTag[0], cyc, csN, shiftStart, tmoFlag, desyncFlag,
                 qCs[0], qSt[0], qTmo[0], qDsy[0]);
      end
      void'(qAt.pop_front()); void'(qCs.pop_front()); void'(qSt.pop_front());
      void'(qTmo.pop_front()); void'(qDsy.pop_front()); void'(qTag.pop_front());
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      failCnt++;
      $display("FAIL watchdog (all requirements): act=hung exp=done by cycle %0d", WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic expectAt(int at, logic [7:0] cs, bit st, bit tmo, bit dsy, string tag);
    qAt.push_back(at); qCs.push_back(cs); qSt.push_back(st);
    qTmo.push_back(tmo); qDsy.push_back(dsy); qTag.push_back(tag);
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Single word, handshake off, hold clear
  task automatic plainWord(logic [7:0] sel, int su, int rl, bit toff, int lenW, string tag);
    int k, s, d0, effSu, effRl;
    @(negedge clk);
    k = cyc;
    delayCfg = {8'(su), 8'(rl), 8'h07, 8'h07};
    timerOff = toff; waitEn = 1'b0; csSel = sel; csHold = 1'b0; readyN = 1'b1;
    effSu = toff ? 0 : su;
    effRl = toff ? 0 : rl;
    s  = k + 1 + effSu;
    d0 = s + lenW + 1;
    expectAt(k + 1, sel, effSu == 0, 0, 0, {tag, " cs asserted"});
    if (effSu > 0) expectAt(s - 1, sel, 0, 0, 0, {tag, " last setup cycle"});
    expectAt(s, sel, 1, 0, 0, {tag, " start pulse"});
    expectAt(s + 1, sel, 0, 0, 0, {tag, " start one cycle"});
    if (effRl > 0) expectAt(d0 + effRl - 1, sel, 0, 0, 0, {tag, " last release cycle"});
    expectAt(d0 + effRl, 8'hFF, 0, 0, 0, {tag, " released"});
    wordReq = 1'b1;
    @(negedge clk);
    wordReq = 1'b0;
    waitUntil(s + lenW);
    shiftDone = 1'b1;
    @(negedge clk);
    shiftDone = 1'b0;
    waitUntil(d0 + effRl + 1);
  endtask

  initial begin
    int k, s, w, d0, d1, j, h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectAt(cyc, 8'hFF, 0, 0, 0, "R1 reset state");
    expectAt(cyc + 1, 8'hFF, 0, 0, 0, "R1 reset state settled");
    @(negedge clk);
    @(negedge clk);

    // R2 idle-level register
    k = cyc;
    idleWr = 1'b1; idleWrData = 8'hA5;
    expectAt(k + 1, 8'hA5, 0, 0, 0, "R2 idle level written");
    expectAt(k + 2, 8'hFF, 0, 0, 0, "R2 idle level restored");
    @(negedge clk);
    idleWrData = 8'hFF;
    @(negedge clk);
    idleWr = 1'b0;
    @(negedge clk);

    // R3 R4 R5 non-zero delays
    plainWord(8'hFB, 3, 2, 1'b0, 2, "R3 R4 R5 delays 3/2");
    // R4 R5 R12 zero delays; readyN high has no effect with handshake off
    plainWord(8'h7F, 0, 0, 1'b0, 1, "R4 R5 R12 zero delays");
    // R6 timer disable
    plainWord(8'hFE, 5, 4, 1'b1, 3, "R6 timer off");

    // R7 hold across words
    @(negedge clk);
    k = cyc;
    delayCfg = {8'd2, 8'd3, 8'd7, 8'd7}; timerOff = 1'b0; waitEn = 1'b0;
    csSel = 8'hEF; csHold = 1'b1; readyN = 1'b1;
    s = k + 3; d0 = s + 2; j = d0 + 2; d1 = j + 3; h = d1 + 2;
    expectAt(k + 1, 8'hEF, 0, 0, 0, "R7 first word asserted");
    expectAt(s, 8'hEF, 1, 0, 0, "R7 first word start");
    expectAt(d0 + 1, 8'hEF, 0, 0, 0, "R7 held between words");
    expectAt(j, 8'hEF, 0, 0, 0, "R7 still held at request");
    expectAt(j + 1, 8'hDF, 1, 0, 0, "R7 next word starts without setup");
    expectAt(d1 + 1, 8'hDF, 0, 0, 0, "R7 held after second word");
    expectAt(h + 2, 8'hDF, 0, 0, 0, "R7 release delay after hold drop");
    expectAt(h + 3, 8'hFF, 0, 0, 0, "R7 released after hold drop");
    wordReq = 1'b1;
    @(negedge clk);
    wordReq = 1'b0;
    waitUntil(s + 1);
    shiftDone = 1'b1;
    @(negedge clk);
    shiftDone = 1'b0;
    waitUntil(j);
    csSel = 8'hDF; wordReq = 1'b1;
    @(negedge clk);
    wordReq = 1'b0;
    @(negedge clk);
    shiftDone = 1'b1;
    @(negedge clk);
    shiftDone = 1'b0;
    @(negedge clk);
    csHold = 1'b0;
    waitUntil(h + 4);

    // R8 R10 handshake, ready arrives late and returns high in time
    @(negedge clk);
    k = cyc;
    delayCfg = {8'd1, 8'd0, 8'd4, 8'd5}; waitEn = 1'b1; timerOff = 1'b0;
    csSel = 8'hFD; csHold = 1'b0; readyN = 1'b1;
    w = k + 2; d0 = w + 5;
    expectAt(k + 1, 8'hFD, 0, 0, 0, "R8 setup before wait");
    expectAt(w + 2, 8'hFD, 0, 0, 0, "R8 waits for ready");
    expectAt(w + 3, 8'hFD, 1, 0, 0, "R8 start after ready low");
    expectAt(d0 + 1, 8'hFD, 0, 0, 0, "R10 waits for ready high");
    expectAt(d0 + 2, 8'hFF, 0, 0, 0, "R10 release after ready high");
    wordReq = 1'b1;
    @(negedge clk);
    wordReq = 1'b0;
    waitUntil(w + 2);
    readyN = 1'b0;
    waitUntil(w + 4);
    shiftDone = 1'b1;
    @(negedge clk);
    shiftDone = 1'b0;
    @(negedge clk);
    readyN = 1'b1;
    waitUntil(d0 + 3);

    // R9 R11 ready timeout, sticky flag, ignored request, clear
    @(negedge clk);
    k = cyc;
    delayCfg = {8'd0, 8'd0, 8'd4, 8'd3}; waitEn = 1'b1;
    csSel = 8'hF7; readyN = 1'b1;
    w = k + 1;
    expectAt(w, 8'hF7, 0, 0, 0, "R9 asserted while waiting");
    expectAt(w + 2, 8'hF7, 0, 0, 0, "R9 before timeout");
    expectAt(w + 3, 8'hFF, 0, 1, 0, "R9 timeout releases");
    expectAt(w + 5, 8'hFF, 0, 1, 0, "R11 request ignored with flag");
    expectAt(w + 6, 8'hFF, 0, 1, 0, "R11 timeout flag sticky");
    expectAt(w + 7, 8'hFF, 0, 0, 0, "R11 timeout flag cleared");
    wordReq = 1'b1;
    @(negedge clk);
    wordReq = 1'b0;
    waitUntil(w + 4);
    wordReq = 1'b1;
    @(negedge clk);
    wordReq = 1'b0;
    waitUntil(w + 6);
    clrTmo = 1'b1;
    @(negedge clk);
    clrTmo = 1'b0;
    @(negedge clk);

    // R10 R11 desync, no release delay on abort
    @(negedge clk);
    k = cyc;
    delayCfg = {8'd0, 8'd3, 8'd2, 8'd10}; waitEn = 1'b1;
    csSel = 8'hBF; readyN = 1'b0;
    w = k + 1; d0 = w + 3;
    expectAt(w, 8'hBF, 0, 0, 0, "R8 waiting one cycle");
    expectAt(w + 1, 8'hBF, 1, 0, 0, "R8 ready already low");
    expectAt(d0 + 1, 8'hBF, 0, 0, 0, "R10 before desync");
    expectAt(d0 + 2, 8'hFF, 0, 0, 1, "R10 desync releases at once");
    expectAt(d0 + 4, 8'hFF, 0, 0, 1, "R11 desync flag sticky");
    expectAt(d0 + 5, 8'hFF, 0, 0, 0, "R11 desync flag cleared");
    wordReq = 1'b1;
    @(negedge clk);
    wordReq = 1'b0;
    waitUntil(w + 2);
    shiftDone = 1'b1;
    @(negedge clk);
    shiftDone = 1'b0;
    waitUntil(d0 + 4);
    clrDesync = 1'b1;
    @(negedge clk);
    clrDesync = 1'b0;
    readyN = 1'b1;
    @(negedge clk);

    // R9 zero timeouts wait without limit
    @(negedge clk);
    k = cyc;
    delayCfg = {8'd0, 8'd0, 8'd0, 8'd0}; waitEn = 1'b1;
    csSel = 8'h7F; readyN = 1'b1;
    w = k + 1; d0 = w + 43;
    expectAt(w + 39, 8'h7F, 0, 0, 0, "R9 zero timeout keeps waiting");
    expectAt(w + 41, 8'h7F, 1, 0, 0, "R9 start after long wait");
    expectAt(d0 + 1, 8'h7F, 0, 0, 0, "R10 zero timeout keeps waiting");
    expectAt(d0 + 2, 8'hFF, 0, 0, 0, "R10 release after ready high");
    wordReq = 1'b1;
    @(negedge clk);
    wordReq = 1'b0;
    waitUntil(w + 40);
    readyN = 1'b0;
    waitUntil(w + 42);
    shiftDone = 1'b1;
    @(negedge clk);
    shiftDone = 1'b0;
    @(negedge clk);
    readyN = 1'b1;
    waitUntil(d0 + 4);

    repeat (3) @(negedge clk);
    if (qAt.size() != 0) begin
      failCnt++;
      $display("FAIL %s: act=%0d items left exp=0", qTag[0], qAt.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule